// File: doc/BRIEF.md
# Streaming NAND Hamming ECC Generator

This block sits beside the byte path between a NAND flash interface and its data mover and computes a single-error-correcting Hamming parity over every 256-byte chunk that passes. The direction of the transfer does not matter. On a page program the parity is formed over outgoing bytes and later written into the spare area. On a page read the parity is formed over incoming bytes and compared against the stored copy by logic outside this block.

Bytes enter with a valid strobe and may arrive with gaps between them. The block tracks each byte's offset inside the current chunk. It accumulates six column-parity bits, which cover groups of bit positions, and sixteen line-parity bits, which cover groups of byte offsets.

When the last byte of a chunk is absorbed, the block does four things:

- It latches the raw parity word into a held output.
- It pulses a completion strobe and tags it with the chunk's index.
- It streams out the three-byte stored form of the parity.
- It starts the next chunk with no idle cycle.

A clear input abandons a partial chunk before a new page begins.

Top module: `nand_ecc_gen`

## Requirements
- R1: A byte is absorbed only on a clock edge where valid_i is high and clr_i is low; idle cycles between bytes leave the result unchanged.
- R2: Column parity sits in raw_par_o[5:0]. For k in 0..2, raw_par_o[2k] is the XOR of every data bit in the chunk whose bit index has bit k equal to 0, and raw_par_o[2k+1] is the XOR of those whose bit index has bit k equal to 1.
- R3: Line parity sits in raw_par_o[21:6]. For a in 0..7, raw_par_o[6+2a] is the XOR of all bits of the bytes whose offset in the chunk has bit a equal to 0, and raw_par_o[7+2a] is the XOR of those whose offset has bit a equal to 1.
- R4: done_o is high for exactly one cycle, the cycle after the edge that absorbs byte 255 of a chunk. raw_par_o takes the chunk's parity on that same edge and holds it until the next chunk completes.
- R5: chunk_idx_o gives the index of the completed chunk. Chunks are counted from 0 after reset or clear, and the count wraps modulo 2^IDX_W (16 by default).
- R6: The stored code is the low 24 bits of the bitwise inverse of raw_par_o shifted left by two. It appears on ecc_byte_o with ecc_valid_o high for three consecutive cycles, starting in the done_o cycle, in the order bits [23:16], then [15:8], then [7:0].
- R7: After a chunk completes, accumulation restarts at once. Byte 0 of the next chunk may arrive on the very next edge.
- R8: clr_i discards a partial chunk, resets the chunk count to 0 and cuts short any stored-code bytes not yet emitted. A byte presented together with clr_i is ignored.
- R9: For two chunks that differ in exactly one data bit, the XOR of their raw parity words has exactly one bit set in each even/odd pair. The odd members, taken in order, give the bit index ({[5],[3],[1]}) and the byte offset ({[21],[19],...,[7]}).
- R10: After reset, done_o and ecc_valid_o are low and raw_par_o and chunk_idx_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of accumulation |
| valid_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Byte on the NAND data path |
| done_o | output | 1 | One-cycle pulse: a chunk has completed |
| chunk_idx_o | output | IDX_W | Index of the completed chunk |
| raw_par_o | output | 22 | Raw parity of the last completed chunk: column in [5:0], line in [21:6] |
| ecc_valid_o | output | 1 | ecc_byte_o carries a stored-code byte |
| ecc_byte_o | output | 8 | Stored-code byte, high byte first |

## Verification
Most internal faults show up at raw_par_o and on the code byte stream of the chunk that is open when the fault occurs, within one chunk time:

- A wrong byte offset puts line parity into the wrong even/odd member.
- A wrong column mask disturbs the bit-index half of the word.
- A stale accumulator that was not cleared after a completion corrupts the following chunk rather than the current one.

A counter fault surfaces differently. done_o arrives early or late, or chunk_idx_o skips or fails to wrap, so the scoreboard sees a completion with no matching expectation. A serializer fault shows as a missing, extra or reordered byte in the three-cycle burst that starts on the done_o cycle.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W     = 8;
  localparam int BIT_IDX_W  = 3;
  localparam int COL_W      = 2 * BIT_IDX_W;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = CODE_BYTES * BYTE_W;

  // bits whose index has bit k set
  function automatic logic [BYTE_W-1:0] odd_mask(input int k);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) m[b] = ((b >> k) & 1) != 0;
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] store_code(input logic [CODE_W-3:0] raw);
    return ~{raw, 2'b00};
  endfunction
endpackage

// File: rtl/ecc_col_unit.sv
module ecc_col_unit
  import nand_ecc_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  output logic [COL_W-1:0]  col_o,
  output logic              par_o
);
  for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_grp
    localparam logic [BYTE_W-1:0] OddM = odd_mask(k);
    assign col_o[2*k]   = ^(data_i & ~OddM);
    assign col_o[2*k+1] = ^(data_i & OddM);
  end
  assign par_o = ^data_i;
endmodule

// File: rtl/ecc_chunk_accum.sv
module ecc_chunk_accum
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int IDX_W       = 4,
  localparam int AddrW      = $clog2(CHUNK_BYTES),
  localparam int LineW      = 2 * AddrW,
  localparam int RawW       = COL_W + LineW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  chunk_idx_o,
  output logic [RawW-1:0]   raw_o,
  output logic              load_o,
  output logic [RawW-1:0]   final_o
);
  logic             take, last;
  logic [AddrW-1:0] off_q;
  logic [COL_W-1:0] col_q, col_c, col_nxt;
  logic [LineW-1:0] line_q, line_nxt;
  logic             par_c;
  logic [IDX_W-1:0] cnt_q;

  ecc_col_unit u_col (.data_i(data_i), .col_o(col_c), .par_o(par_c));

  assign take    = valid_i & ~clr_i;
  assign last    = &off_q;
  assign col_nxt = col_q ^ ({COL_W{take}} & col_c);

  for (genvar a = 0; a < AddrW; a++) begin : g_line
    assign line_nxt[2*a]   = line_q[2*a]   ^ (take & ~off_q[a] & par_c);
    assign line_nxt[2*a+1] = line_q[2*a+1] ^ (take &  off_q[a] & par_c);
  end

  assign final_o = {line_nxt, col_nxt};
  assign load_o  = take & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q       <= '0;
      col_q       <= '0;
      line_q      <= '0;
      cnt_q       <= '0;
      chunk_idx_o <= '0;
      raw_o       <= '0;
      done_o      <= 1'b0;
    end else if (clr_i) begin
      off_q       <= '0;
      col_q       <= '0;
      line_q      <= '0;
      cnt_q       <= '0;
      chunk_idx_o <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= take & last;
      if (take) begin
        off_q <= off_q + 1'b1;
        if (last) begin
          col_q       <= '0;
          line_q      <= '0;
          raw_o       <= final_o;
          chunk_idx_o <= cnt_q;
          cnt_q       <= cnt_q + 1'b1;
        end else begin
          col_q  <= col_nxt;
          line_q <= line_nxt;
        end
      end
    end
  end

  // R4: single-cycle completion strobe
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1: completion only follows an absorbed byte
  p_done_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && !clr_i));
  // R8: clear restarts the chunk count
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && chunk_idx_o == '0));
endmodule

// File: rtl/ecc_code_emit.sv
module ecc_code_emit
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CntW = $clog2(CODE_BYTES + 1);

  logic [CODE_W-1:0] sr_q;
  logic [CntW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= code_i;
      cnt_q <= CntW'(CODE_BYTES);
    end else if (cnt_q != '0) begin
      sr_q  <= sr_q << BYTE_W;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = cnt_q != '0;
  assign byte_o  = sr_q[CODE_W-1 -: BYTE_W];

  // R6: an uninterrupted burst lasts three cycles
  p_burst_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(valid_o) && !$past(clr_i)) |-> ($past(valid_o, 3) && !$past(valid_o, 4)));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int IDX_W       = 4,
  localparam int AddrW      = $clog2(CHUNK_BYTES),
  localparam int RawW       = COL_W + 2 * AddrW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output logic [IDX_W-1:0] chunk_idx_o,
  output logic [RawW-1:0]  raw_par_o,
  output logic             ecc_valid_o,
  output logic [7:0]       ecc_byte_o
);
  logic            load;
  logic [RawW-1:0] final_raw;
  logic [CODE_W-1:0] code;

  ecc_chunk_accum #(.CHUNK_BYTES(CHUNK_BYTES), .IDX_W(IDX_W)) u_acc (
    .clk_i, .rst_ni, .clr_i, .valid_i, .data_i,
    .done_o, .chunk_idx_o, .raw_o(raw_par_o),
    .load_o(load), .final_o(final_raw)
  );

  assign code = store_code((CODE_W-2)'(final_raw));

  ecc_code_emit u_emit (
    .clk_i, .rst_ni, .clr_i, .load_i(load), .code_i(code),
    .valid_o(ecc_valid_o), .byte_o(ecc_byte_o)
  );

  logic [CODE_W-1:0] held_code;
  assign held_code = store_code((CODE_W-2)'(raw_par_o));

  // R6: first emitted byte matches the high byte of the held raw word's code
  p_first_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ecc_valid_o && ecc_byte_o == held_code[CODE_W-1 -: 8]));
endmodule

// File: tb/sim_nand_ecc_gen.sv
`timescale 1ns/1ps
module sim_nand_ecc_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       done_o;
  logic [3:0] chunk_idx_o;
  logic [21:0] raw_par_o;
  logic       ecc_valid_o;
  logic [7:0] ecc_byte_o;

  always #4 clk_i = ~clk_i;

  nand_ecc_gen #(.CHUNK_BYTES(256), .IDX_W(4)) u0 (.*);

  typedef struct { logic [21:0] raw; logic [3:0] idx; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] byte_q[$];
  logic [7:0] buf_m[256];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [21:0] ref_raw();
    logic [21:0] r = '0;
    for (int o = 0; o < 256; o++)
      for (int b = 0; b < 8; b++)
        if (buf_m[o][b]) begin
          for (int k = 0; k < 3; k++) r[2*k + ((b >> k) & 1)] ^= 1'b1;
          for (int a = 0; a < 8; a++) r[6 + 2*a + ((o >> a) & 1)] ^= 1'b1;
        end
    return r;
  endfunction

  // driver: pushes expectations, then streams buf_m
  task automatic send_chunk(input int bubble, input logic [3:0] idx, input int nbytes);
    exp_t e;
    logic [23:0] c;
    e.raw = ref_raw();
    e.idx = idx;
    exp_q.push_back(e);
    c = ~{e.raw, 2'b00};
    if (nbytes > 0) byte_q.push_back(c[23:16]);
    if (nbytes > 1) byte_q.push_back(c[15:8]);
    if (nbytes > 2) byte_q.push_back(c[7:0]);
    for (int i = 0; i < 256; i++) begin
      valid_i = 1'b1;
      data_i  = buf_m[i];
      @(posedge clk_i); #1;
      if (bubble != 0 && (i % bubble) == 0) begin
        valid_i = 1'b0;
        data_i  = 8'hFF;
        @(posedge clk_i); #1;
      end
    end
    valid_i = 1'b0;
  endtask

  // monitor: scoreboard compare
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(raw_par_o == e.raw, "R2 R3 raw parity", 32'(raw_par_o), 32'(e.raw));
          chk(chunk_idx_o == e.idx, "R5 chunk index", 32'(chunk_idx_o), 32'(e.idx));
        end
      end
      if (ecc_valid_o) begin
        if (byte_q.size() == 0) chk(0, "R6 R8 unexpected code byte", 32'(ecc_byte_o), 0);
        else begin
          logic [7:0] eb;
          eb = byte_q.pop_front();
          chk(ecc_byte_o == eb, "R6 code byte", 32'(ecc_byte_o), 32'(eb));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [21:0] ra, rb, d;
    logic [3:0]  idx;
    repeat (3) @(posedge clk_i);
    #1;
    chk(done_o == 0 && ecc_valid_o == 0, "R10 strobes low", {30'b0, done_o, ecc_valid_o}, 0);
    chk(raw_par_o == 0, "R10 raw zero", 32'(raw_par_o), 0);
    chk(chunk_idx_o == 0, "R10 idx zero", 32'(chunk_idx_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // all zeros
    for (int i = 0; i < 256; i++) buf_m[i] = 8'h00;
    send_chunk(0, 4'd0, 3);
    // single set bit at offset 0 bit 0 (R2 R3)
    buf_m[0] = 8'h01;
    send_chunk(0, 4'd1, 3);
    // ramp with bubbles (R1)
    for (int i = 0; i < 256; i++) buf_m[i] = 8'(i * 7 + 3);
    send_chunk(3, 4'd2, 3);

    // R9: one flipped bit
    for (int i = 0; i < 256; i++) buf_m[i] = 8'($urandom);
    send_chunk(0, 4'd3, 3);
    ra = raw_par_o;
    buf_m[8'hA5][6] = ~buf_m[8'hA5][6];
    send_chunk(0, 4'd4, 3);
    rb = raw_par_o;
    d = ra ^ rb;
    chk($countones(d) == 11, "R9 flipped count", 32'($countones(d)), 11);
    for (int p = 0; p < 11; p++)
      chk(d[2*p] ^ d[2*p+1], "R9 pair toggle", 32'(d[2*p+1 -: 2]), 1);
    chk({d[5], d[3], d[1]} == 3'd6, "R9 bit index", 32'({d[5], d[3], d[1]}), 6);
    chk({d[21], d[19], d[17], d[15], d[13], d[11], d[9], d[7]} == 8'hA5, "R9 offset",
        32'({d[21], d[19], d[17], d[15], d[13], d[11], d[9], d[7]}), 32'hA5);

    // back-to-back chunks (R7) through index wrap (R5)
    for (int c = 5; c < 17; c++) begin
      for (int i = 0; i < 256; i++) buf_m[i] = 8'($urandom);
      idx = 4'(c);
      send_chunk(0, idx, 3);
    end

    // R8: partial chunk then clear with a byte on the same cycle
    for (int i = 0; i < 100; i++) begin
      valid_i = 1'b1; data_i = 8'($urandom);
      @(posedge clk_i); #1;
    end
    clr_i = 1'b1; valid_i = 1'b1; data_i = 8'hFF;
    @(posedge clk_i); #1;
    clr_i = 1'b0; valid_i = 1'b0;
    chk(chunk_idx_o == 0, "R8 idx after clear", 32'(chunk_idx_o), 0);
    for (int i = 0; i < 256; i++) buf_m[i] = 8'($urandom);
    send_chunk(0, 4'd0, 3);
    repeat (4) @(posedge clk_i); #1;

    // R8: clear cuts the code burst after its first byte
    for (int i = 0; i < 256; i++) buf_m[i] = 8'($urandom);
    send_chunk(0, 4'd1, 1);
    clr_i = 1'b1;
    @(posedge clk_i); #1;
    clr_i = 1'b0;
    for (int i = 0; i < 256; i++) buf_m[i] = 8'(255 - i);
    send_chunk(2, 4'd0, 3);

    repeat (10) @(posedge clk_i); #1;
    chk(exp_q.size() == 0, "R4 missing done", 32'(exp_q.size()), 0);
    chk(byte_q.size() == 0, "R6 missing code bytes", 32'(byte_q.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule